// File: doc/BRIEF.md
# DMA Status and Interrupt Aggregator

This block keeps the transmit and receive completion status of an Ethernet MAC's DMA engines and folds it into a single level-sensitive interrupt. The DMA engines report each finished packet and each error event (transmit underrun, receive overflow) with a one-cycle pulse. Each direction has a status word that holds an 8-bit count of packets not yet acknowledged, a "done" flag and an error flag.

Software reads and writes four 32-bit words through a simple register port with a combinational read path. Packets are acknowledged one at a time: a 1 written to the done flag takes one packet off the count, and the flag only drops once nothing is left outstanding. Error flags are write-one-to-clear. An 8-bit enable mask selects which status flags can drive the interrupt line. The masked value can be read back from a fourth word, which is read-only.

Top module: `dma_irq_aggregator`

## Requirements
- R1: After synchronous reset every word reads 0 and `irq_o` is low. Register map by byte offset: 0x0 transmit status, 0x4 receive status, 0x8 enable mask, 0xC masked interrupt. Any other offset reads 0.
- R2: In each status word the packet count sits in bits 23:16 and the done flag in bit 0. A completion pulse adds one to the count and sets the done flag, both visible one clock later.
- R3: Writing a word with bit 0 set to a status offset subtracts one from that direction's count. The done flag stays set while the count is still nonzero, and clears on the write that takes the count to zero.
- R4: If a completion pulse and an acknowledge write reach the same direction in the same cycle, the count keeps its value and the done flag is set.
- R5: The count saturates. It stays at 255 on further completions, and an acknowledge at 0 leaves it at 0.
- R6: An underrun pulse sets transmit bit 1 and an overflow pulse sets receive bit 2. Writing 1 to that bit clears it. When a pulse and a clear arrive in the same cycle, the flag ends up set.
- R7: The raw vector is {receive bits 3:0, transmit bits 3:0}. Offset 0xC reads the enable mask ANDed with the raw vector. The mask keeps bits 7:0 only, and its upper bits read 0.
- R8: Writes to offset 0xC change nothing. Data bits that are 0 in a status write leave that status word unchanged.
- R9: `irq_o` is high exactly when the masked value is nonzero. It is derived combinationally from registered state, so it follows a status or mask change in the same cycle that change becomes visible on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_done_i | input | 1 | Transmit packet completion pulse |
| tx_underrun_i | input | 1 | Transmit underrun event pulse |
| rx_done_i | input | 1 | Receive packet completion pulse |
| rx_overflow_i | input | 1 | Receive overflow event pulse |
| reg_addr_i | input | 4 | Byte offset of the register access |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
The packet counter is exercised in three ways. A burst of completions followed by single acknowledges shows that the done flag survives until the last acknowledge. A pulse and an acknowledge in the same cycle show the hold rule, as opposed to a net increment or decrement. A burst of several hundred pulses, followed by acknowledges at zero, separates saturation from wrap-around. The mask is tried with single enabled bits against each error and done flag, so that the mapping of each nibble into the raw vector and the level of `irq_o` can be told apart. Writes with zero data bits, and writes to the read-only word, show that nothing outside the write-one bits is touched.

// File: rtl/dma_irq_agg_pkg.sv
package dma_irq_agg_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int CNT_W   = 8;
    localparam int CNT_LSB = 16;
    localparam int VEC_W   = 4;
    localparam int RAW_W   = 2 * VEC_W;
    localparam int NUM_DIR = 2;
    localparam int DIR_TX  = 0;
    localparam int DIR_RX  = 1;
    localparam int DONE_POS = 0;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef enum logic [1:0] {
        SEL_TX_STAT = 2'd0,
        SEL_RX_STAT = 2'd1,
        SEL_MASK    = 2'd2,
        SEL_IRQ     = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             err;
        logic             done;
    } dir_stat_t;

    typedef struct packed {
        logic set_done;
        logic ack_done;
        logic set_err;
        logic clr_err;
    } dir_evt_t;

    function automatic int err_pos(input int dir);
        return (dir == DIR_TX) ? 1 : 2;
    endfunction

    function automatic logic [CNT_W-1:0] count_step(
        input logic [CNT_W-1:0] cnt,
        input logic             inc,
        input logic             dec
    );
        logic [CNT_W-1:0] r;
        r = cnt;
        if (inc && !dec && (cnt != CNT_MAX)) begin
            r = cnt + 1'b1;
        end else if (dec && !inc && (cnt != '0)) begin
            r = cnt - 1'b1;
        end
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] pack_word(
        input dir_stat_t s,
        input int        epos
    );
        logic [DATA_W-1:0] w;
        w = '0;
        w[CNT_LSB +: CNT_W] = s.count;
        w[DONE_POS]         = s.done;
        w[epos]             = s.err;
        return w;
    endfunction

endpackage

// File: rtl/dma_dir_status.sv
module dma_dir_status
    import dma_irq_agg_pkg::*;
#(
    parameter int ERR_POS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  dir_evt_t          evt,
    output logic [DATA_W-1:0] word
);

    dir_stat_t stat_q;
    dir_stat_t stat_d;

    always_comb begin
        stat_d       = stat_q;
        stat_d.count = count_step(stat_q.count, evt.set_done, evt.ack_done);
        if (evt.set_done) begin
            stat_d.done = 1'b1;
        end else if (evt.ack_done) begin
            stat_d.done = (stat_d.count != '0);
        end
        if (evt.set_err) begin
            stat_d.err = 1'b1;
        end else if (evt.clr_err) begin
            stat_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign word = pack_word(stat_q, ERR_POS);

endmodule

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
    import dma_irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [DATA_W-1:0] rx_word,
    input  logic [RAW_W-1:0]  masked,
    output logic [NUM_DIR-1:0] ack,
    output logic [NUM_DIR-1:0] clr,
    output logic [RAW_W-1:0]  mask_q,
    output logic [DATA_W-1:0] rdata
);

    reg_sel_e sel;
    logic     aligned;

    assign sel     = reg_sel_e'(addr[ADDR_W-1:2]);
    assign aligned = (addr[1:0] == 2'b00);

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir_wr
        localparam reg_sel_e DSEL = (d == DIR_TX) ? SEL_TX_STAT : SEL_RX_STAT;
        logic hit;
        assign hit    = wr && aligned && (sel == DSEL);
        assign ack[d] = hit && wdata[DONE_POS];
        assign clr[d] = hit && wdata[err_pos(d)];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr && aligned && (sel == SEL_MASK)) begin
            mask_q <= wdata[RAW_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            unique case (sel)
                SEL_TX_STAT: rdata = tx_word;
                SEL_RX_STAT: rdata = rx_word;
                SEL_MASK:    rdata[RAW_W-1:0] = mask_q;
                SEL_IRQ:     rdata[RAW_W-1:0] = masked;
                default:     rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dma_irq_combine.sv
module dma_irq_combine
    import dma_irq_agg_pkg::*;
(
    input  logic [DATA_W-1:0] tx_word,
    input  logic [DATA_W-1:0] rx_word,
    input  logic [RAW_W-1:0]  mask,
    output logic [RAW_W-1:0]  masked,
    output logic              irq
);

    logic [RAW_W-1:0] raw;

    assign raw    = {rx_word[VEC_W-1:0], tx_word[VEC_W-1:0]};
    assign masked = raw & mask;
    assign irq    = |masked;

endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator
    import dma_irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_done_i,
    input  logic              tx_underrun_i,
    input  logic              rx_done_i,
    input  logic              rx_overflow_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);

    logic [NUM_DIR-1:0] done_pulse;
    logic [NUM_DIR-1:0] err_pulse;
    logic [NUM_DIR-1:0] ack;
    logic [NUM_DIR-1:0] clr;
    logic [DATA_W-1:0]  stat_word [NUM_DIR];
    logic [DATA_W-1:0]  tx_status_w;
    logic [DATA_W-1:0]  rx_status_w;
    logic [RAW_W-1:0]   mask_q;
    logic [RAW_W-1:0]   masked;

    assign done_pulse = {rx_done_i, tx_done_i};
    assign err_pulse  = {rx_overflow_i, tx_underrun_i};

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        dir_evt_t evt;
        assign evt.set_done = done_pulse[d];
        assign evt.ack_done = ack[d];
        assign evt.set_err  = err_pulse[d];
        assign evt.clr_err  = clr[d];

        dma_dir_status #(
            .ERR_POS(err_pos(d))
        ) u_stat (
            .clk  (clk),
            .rst  (rst),
            .evt  (evt),
            .word (stat_word[d])
        );
    end

    assign tx_status_w = stat_word[DIR_TX];
    assign rx_status_w = stat_word[DIR_RX];

    dma_reg_decode u_dec (
        .clk     (clk),
        .rst     (rst),
        .addr    (reg_addr_i),
        .wr      (reg_wr_i),
        .wdata   (reg_wdata_i),
        .tx_word (tx_status_w),
        .rx_word (rx_status_w),
        .masked  (masked),
        .ack     (ack),
        .clr     (clr),
        .mask_q  (mask_q),
        .rdata   (reg_rdata_o)
    );

    dma_irq_combine u_irq (
        .tx_word (tx_status_w),
        .rx_word (rx_status_w),
        .mask    (mask_q),
        .masked  (masked),
        .irq     (irq_o)
    );

endmodule

// File: rtl/dma_irq_aggregator_chk.sv
module dma_irq_aggregator_chk
    import dma_irq_agg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tx_done_i,
    input logic              tx_underrun_i,
    input logic              rx_overflow_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic              reg_wr_i,
    input logic [DATA_W-1:0] reg_wdata_i,
    input logic [DATA_W-1:0] tx_w,
    input logic [DATA_W-1:0] rx_w,
    input logic [RAW_W-1:0]  mask_w,
    input logic              irq_o
);

    logic             tx_ack;
    logic             irq_wr;
    logic [CNT_W-1:0] tx_cnt;

    assign tx_ack = reg_wr_i && (reg_addr_i == 4'h0) && reg_wdata_i[0];
    assign irq_wr = reg_wr_i && (reg_addr_i == 4'hC);
    assign tx_cnt = tx_w[CNT_LSB +: CNT_W];

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (tx_w == '0 && rx_w == '0 && mask_w == '0 && !irq_o)); // R1

    AST_TX_COUNT_INC: assert property (@(posedge clk) disable iff (rst)
        (tx_done_i && !tx_ack && tx_cnt != CNT_MAX)
        |=> (tx_cnt == $past(tx_cnt) + 1'b1) && tx_w[0]); // R2

    AST_TX_ACK_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (tx_ack && !tx_done_i && tx_cnt > 8'd1)
        |=> (tx_cnt == $past(tx_cnt) - 1'b1) && tx_w[0]); // R3

    AST_TX_ACK_LAST: assert property (@(posedge clk) disable iff (rst)
        (tx_ack && !tx_done_i && tx_cnt <= 8'd1)
        |=> (tx_cnt == '0) && !tx_w[0]); // R3

    AST_TX_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_ack && tx_done_i) |=> $stable(tx_cnt) && tx_w[0]); // R4

    AST_TX_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (tx_done_i && !tx_ack && tx_cnt == CNT_MAX) |=> tx_cnt == CNT_MAX); // R5

    AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (rst)
        tx_underrun_i |=> tx_w[1]); // R6

    AST_OVERFLOW_SET: assert property (@(posedge clk) disable iff (rst)
        rx_overflow_i |=> rx_w[2]); // R6

    AST_IRQ_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        irq_wr |=> $stable(mask_w)); // R8

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        irq_o == |(mask_w & {rx_w[VEC_W-1:0], tx_w[VEC_W-1:0]})); // R9

endmodule

bind dma_irq_aggregator dma_irq_aggregator_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .tx_done_i     (tx_done_i),
    .tx_underrun_i (tx_underrun_i),
    .rx_overflow_i (rx_overflow_i),
    .reg_addr_i    (reg_addr_i),
    .reg_wr_i      (reg_wr_i),
    .reg_wdata_i   (reg_wdata_i),
    .tx_w          (tx_status_w),
    .rx_w          (rx_status_w),
    .mask_w        (mask_q),
    .irq_o         (irq_o)
);

// File: tb/dma_irq_aggregator_tb.sv
module dma_irq_aggregator_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_done_i = 1'b0;
    logic        tx_underrun_i = 1'b0;
    logic        rx_done_i = 1'b0;
    logic        rx_overflow_i = 1'b0;
    logic [3:0]  reg_addr_i = 4'h0;
    logic        reg_wr_i = 1'b0;
    logic [31:0] reg_wdata_i = 32'h0;
    logic [31:0] reg_rdata_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] exp_data;
        logic        exp_irq;
        string       tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    event      sample_ev;

    always #10 clk = ~clk;

    dma_irq_aggregator u_dut (
        .clk           (clk),
        .rst           (rst),
        .tx_done_i     (tx_done_i),
        .tx_underrun_i (tx_underrun_i),
        .rx_done_i     (rx_done_i),
        .rx_overflow_i (rx_overflow_i),
        .reg_addr_i    (reg_addr_i),
        .reg_wr_i      (reg_wr_i),
        .reg_wdata_i   (reg_wdata_i),
        .reg_rdata_o   (reg_rdata_o),
        .irq_o         (irq_o)
    );

    // Monitor: pops one expected item per sample event and compares.
    initial begin
        forever begin
            @(sample_ev);
            #1;
            if (exp_q.size() > 0) begin
                exp_item_t it;
                it = exp_q.pop_front();
                checks++;
                if (reg_rdata_o !== it.exp_data || irq_o !== it.exp_irq) begin
                    errors++;
                    $display("FAIL %s: data=%h irq=%b expected data=%h irq=%b",
                             it.tag, reg_rdata_o, irq_o, it.exp_data, it.exp_irq);
                end
            end
        end
    end

    task automatic expect_reg(input logic [3:0] a, input logic [31:0] d,
                              input logic ei, input string tag);
        exp_item_t it;
        @(negedge clk);
        reg_addr_i = a;
        it.exp_data = d;
        it.exp_irq  = ei;
        it.tag      = tag;
        exp_q.push_back(it);
        -> sample_ev;
        #3;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr_i  = a;
        reg_wdata_i = d;
        reg_wr_i    = 1'b1;
        @(negedge clk);
        reg_wr_i    = 1'b0;
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        expect_reg(4'h0, 32'h0, 1'b0, "R1 tx status");
        expect_reg(4'h4, 32'h0, 1'b0, "R1 rx status");
        expect_reg(4'h8, 32'h0, 1'b0, "R1 mask");
        expect_reg(4'hC, 32'h0, 1'b0, "R1 irq word");

        // R2: three completions
        @(negedge clk); tx_done_i = 1'b1;
        repeat (3) @(negedge clk);
        tx_done_i = 1'b0;
        expect_reg(4'h0, 32'h0003_0001, 1'b0, "R2 count three");

        // R3: acknowledges one at a time
        wr(4'h0, 32'h1);
        expect_reg(4'h0, 32'h0002_0001, 1'b0, "R3 ack to two");
        wr(4'h0, 32'h1);
        expect_reg(4'h0, 32'h0001_0001, 1'b0, "R3 ack to one");
        wr(4'h0, 32'h1);
        expect_reg(4'h0, 32'h0000_0000, 1'b0, "R3 ack to zero clears flag");

        // R7, R9: receive done with mask bit 4
        @(negedge clk); rx_done_i = 1'b1;
        @(negedge clk); rx_done_i = 1'b0;
        wr(4'h8, 32'hFFFF_FF10);
        expect_reg(4'h8, 32'h0000_0010, 1'b1, "R7 mask upper bits dropped");
        expect_reg(4'hC, 32'h0000_0010, 1'b1, "R9 irq from rx done");

        // R8: read-only word and zero data bits
        wr(4'hC, 32'hFFFF_FFFF);
        expect_reg(4'h8, 32'h0000_0010, 1'b1, "R8 mask untouched");
        wr(4'h4, 32'hFFFF_FFFA);
        expect_reg(4'h4, 32'h0001_0001, 1'b1, "R8 zero bits no effect");

        // R4: completion and ack together
        @(negedge clk);
        rx_done_i = 1'b1;
        reg_addr_i = 4'h4; reg_wdata_i = 32'h1; reg_wr_i = 1'b1;
        @(negedge clk);
        rx_done_i = 1'b0; reg_wr_i = 1'b0;
        expect_reg(4'h4, 32'h0001_0001, 1'b1, "R4 simultaneous hold");

        // R6, R9: overflow with mask bit 6
        @(negedge clk); rx_overflow_i = 1'b1;
        @(negedge clk); rx_overflow_i = 1'b0;
        wr(4'h8, 32'h40);
        expect_reg(4'h4, 32'h0001_0005, 1'b1, "R6 overflow set");
        expect_reg(4'hC, 32'h0000_0040, 1'b1, "R7 overflow nibble position");
        wr(4'h4, 32'h4);
        expect_reg(4'h4, 32'h0001_0001, 1'b0, "R6 overflow cleared");
        expect_reg(4'hC, 32'h0, 1'b0, "R9 irq drops");

        // R6: underrun set wins over clear
        wr(4'h8, 32'h02);
        @(negedge clk);
        tx_underrun_i = 1'b1;
        reg_addr_i = 4'h0; reg_wdata_i = 32'h2; reg_wr_i = 1'b1;
        @(negedge clk);
        tx_underrun_i = 1'b0; reg_wr_i = 1'b0;
        expect_reg(4'h0, 32'h0000_0002, 1'b1, "R6 set wins");
        wr(4'h0, 32'h2);
        expect_reg(4'h0, 32'h0, 1'b0, "R6 underrun cleared");

        // R5: saturation at 255
        @(negedge clk); tx_done_i = 1'b1;
        repeat (260) @(negedge clk);
        tx_done_i = 1'b0;
        expect_reg(4'h0, 32'h00FF_0001, 1'b0, "R5 saturate high");
        wr(4'h0, 32'h1);
        expect_reg(4'h0, 32'h00FE_0001, 1'b0, "R5 ack after saturation");

        // R5: ack at zero
        wr(4'h4, 32'h1);
        expect_reg(4'h4, 32'h0, 1'b0, "R3 rx ack to zero");
        wr(4'h4, 32'h1);
        expect_reg(4'h4, 32'h0, 1'b0, "R5 no wrap below zero");

        // R1: unmapped offset reads zero
        expect_reg(4'h2, 32'h0, 1'b0, "R1 unaligned offset");

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule